// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is a configurable two-level logic array. It has twelve primary inputs, fifty product terms and six outputs. Each product term is the AND of a chosen set of input literals, where a literal is the true form or the inverted form of an input. Each output is the OR of a chosen set of product terms. Any truth table over the inputs can be built this way, as long as it fits in the available terms.

The connections are held as configuration bits. A bit of 1 means the connection is present and a bit of 0 means it has been removed. Reset sets every bit to 1, which matches an unprogrammed device. Software loads the array through a write port. One write replaces one term's literal row or one output's term column. After loading, the path from `in_i` to `out_o` contains no registers.

Top module: `pla_array`

## Requirements
- R1: After reset every connection bit is 1, so every term has both forms of each input and `out_o` is 0 for every input pattern.
- R2: A write with `cfg_plane_i`=0 and `cfg_idx_i` < 50 replaces that term's row with `cfg_data_i[23:0]`. Bit 2i connects the true form of input i, and bit 2i+1 connects its inverted form.
- R3: A write with `cfg_plane_i`=1 and `cfg_idx_i` < 6 replaces that output's column with `cfg_data_i[49:0]`. Bit t connects product term t.
- R4: `out_o` shows the old configuration up to the clock edge that takes a write, and shows the new configuration right after that edge.
- R5: A product term is 1 when all of its connected literals are 1. A term with no connected literals is always 1.
- R6: A product term that has both forms of any one input connected is always 0.
- R7: Each output is the OR of its connected product terms. An output with no connected terms is always 0.
- R8: A write whose index is out of range (50 or more for rows, 6 or more for columns) changes no configuration bit.
- R9: `out_o` follows a change on `in_i` with no clock edge in between.
- R10: A write changes only the row or column it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration write port |
| rst_ni | input | 1 | Active-low asynchronous reset; sets all connections to intact |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_plane_i | input | 1 | Selects the plane: 0 = term row (AND plane), 1 = output column (OR plane) |
| cfg_idx_i | input | 6 | Row or column index |
| cfg_data_i | input | 50 | Write data: low 24 bits for a row, 50 bits for a column |
| in_i | input | 12 | Primary inputs |
| out_o | output | 6 | Sum-of-products outputs |

## Verification
The bench loads a 3-input majority function into four terms and sweeps all eight input combinations. It also covers a term with no literals connected, a term that holds both forms of one input, and an output with an empty column. A design that treated an empty term as 0 would hold output 1 low, and one that only wrote the true literal would not see the conflicting term forced to 0. Writes with out-of-range indices of 50 and 6 are issued and then observed at the outputs. A design that wrapped or truncated the index would corrupt a live term or column, and the majority output would change. A reference model compares `out_o` on every clock, and extra checks are timed just before and just after each write edge. Together these catch an update that lands a cycle late or a cycle early, and an output that needs a clock edge to follow a new input.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic {
    PLANE_AND = 1'b0,
    PLANE_OR  = 1'b1
  } plane_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int unsigned N_IN   = 12,
  parameter int unsigned N_TERM = 50,
  parameter int unsigned IDX_W  = 6,
  localparam int unsigned ROW_W = 2 * N_IN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [N_IN-1:0]   in_i,
  output logic [N_TERM-1:0] term_o
);

  logic [ROW_W-1:0] row_q [N_TERM];
  logic [N_TERM*ROW_W-1:0] row_flat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < N_TERM; t++) row_q[t] <= '1;
    end else if (we_i) begin
      for (int t = 0; t < N_TERM; t++) begin
        if (idx_i == IDX_W'(t)) row_q[t] <= row_i;
      end
    end
  end

  // even bit: true literal, odd bit: inverted literal
  always_comb begin
    for (int t = 0; t < N_TERM; t++) begin
      term_o[t] = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        if (row_q[t][2*i]   && !in_i[i]) term_o[t] = 1'b0;
        if (row_q[t][2*i+1] &&  in_i[i]) term_o[t] = 1'b0;
      end
    end
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_flat
    assign row_flat[t*ROW_W +: ROW_W] = row_q[t];
  end

  p_row_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (idx_i < IDX_W'(N_TERM))) |=> (row_q[$past(idx_i)] == $past(row_i)));

  p_oob_row_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (idx_i >= IDX_W'(N_TERM))) |=> $stable(row_flat));

  p_idle_row_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(row_flat));

  for (genvar t = 0; t < N_TERM; t++) begin : g_chk
    logic [N_IN-1:0] conflict;
    for (genvar i = 0; i < N_IN; i++) begin : g_bit
      assign conflict[i] = row_q[t][2*i] & row_q[t][2*i+1];
    end
    p_conflict_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|conflict) |-> !term_o[t]);
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int unsigned N_TERM = 50,
  parameter int unsigned N_OUT  = 6,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [N_TERM-1:0] col_i,
  input  logic [N_TERM-1:0] term_i,
  output logic [N_OUT-1:0]  out_o
);

  logic [N_TERM-1:0] col_q [N_OUT];
  logic [N_OUT*N_TERM-1:0] col_flat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_OUT; k++) col_q[k] <= '1;
    end else if (we_i) begin
      for (int k = 0; k < N_OUT; k++) begin
        if (idx_i == IDX_W'(k)) col_q[k] <= col_i;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < N_OUT; k++) out_o[k] = |(term_i & col_q[k]);
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_flat
    assign col_flat[k*N_TERM +: N_TERM] = col_q[k];
    p_empty_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (col_q[k] == '0) |-> !out_o[k]);
  end

  p_col_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (idx_i < IDX_W'(N_OUT))) |=> (col_q[$past(idx_i)] == $past(col_i)));

  p_oob_col_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (idx_i >= IDX_W'(N_OUT))) |=> $stable(col_flat));

endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int unsigned N_IN   = 12,
  parameter int unsigned N_TERM = 50,
  parameter int unsigned N_OUT  = 6,
  localparam int unsigned ROW_W  = 2 * N_IN,
  localparam int unsigned DATA_W = max_u(ROW_W, N_TERM),
  localparam int unsigned IDX_W  = $clog2(max_u(N_TERM, N_OUT) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_plane_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  input  logic [N_IN-1:0]   in_i,
  output logic [N_OUT-1:0]  out_o
);

  logic              we_and, we_or;
  logic [N_TERM-1:0] term;

  assign we_and = cfg_we_i && (cfg_plane_i == PLANE_AND);
  assign we_or  = cfg_we_i && (cfg_plane_i == PLANE_OR);

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM), .IDX_W(IDX_W)) u_and (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_and),
    .idx_i  (cfg_idx_i),
    .row_i  (cfg_data_i[ROW_W-1:0]),
    .in_i   (in_i),
    .term_o (term)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT), .IDX_W(IDX_W)) u_or (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_or),
    .idx_i  (cfg_idx_i),
    .col_i  (cfg_data_i[N_TERM-1:0]),
    .term_i (term),
    .out_o  (out_o)
  );

  p_never_write_both_planes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({we_and, we_or}) <= 1);

endmodule

// File: tb/pla_array_tb_top.sv
`timescale 1ns/1ps
module pla_array_tb_top;

  localparam int NI = 12, NT = 50, NO = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        plane = 1'b0;
  logic [5:0]  idx = '0;
  logic [49:0] data = '0;
  logic [11:0] in_s = '0;
  logic [5:0]  out_w;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [23:0] and_m [NT];
  logic [49:0] or_m  [NO];

  always #2.5 clk = ~clk;

  pla_array dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_plane_i(plane),
    .cfg_idx_i(idx), .cfg_data_i(data), .in_i(in_s), .out_o(out_w)
  );

  function automatic logic [5:0] model(input logic [11:0] x);
    logic [5:0] r = '0;
    for (int t = 0; t < NT; t++) begin
      bit p = 1;
      for (int i = 0; i < NI; i++) begin
        if (and_m[t][2*i] && !x[i]) p = 0;
        if (and_m[t][2*i+1] && x[i]) p = 0;
      end
      for (int k = 0; k < NO; k++) if (p && or_m[k][t]) r[k] = 1'b1;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // reference compare on every clock
  always @(negedge clk) if (rst_n && !done) chk("R7 per-clock model", out_w, model(in_s));

  task automatic wr(input logic pl, input int ix, input logic [49:0] d);
    @(posedge clk); #1;
    we = 1'b1; plane = pl; idx = 6'(ix); data = d;
    #0.5 chk("R4 old config before edge", out_w, model(in_s));
    @(posedge clk); #1;
    we = 1'b0;
    if (!pl && ix < NT) and_m[ix] = d[23:0];
    if (pl && ix < NO) or_m[ix] = d;
    #0.5 chk("R4 new config after edge", out_w, model(in_s));
  endtask

  task automatic drive(input logic [11:0] x);
    @(posedge clk); #1; in_s = x;
  endtask

  initial begin
    for (int t = 0; t < NT; t++) and_m[t] = '1;
    for (int k = 0; k < NO; k++) or_m[k] = '1;
    #1;
    chk("R1 reset outputs zero", out_w, 6'd0);
    in_s = 12'hA5C; #1;
    chk("R1 reset outputs zero pattern", out_w, 6'd0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R2: majority of inputs 0..2 on terms 0..3, R3: column 0
    wr(1'b0, 0, 50'h005);
    wr(1'b0, 1, 50'h011);
    wr(1'b0, 2, 50'h014);
    wr(1'b0, 3, 50'h015);
    for (int t = 4; t < NT; t++) wr(1'b0, t, 50'h0 | 24'hFFFFFF);
    for (int k = 0; k < NO; k++) wr(1'b1, k, 50'h0);
    wr(1'b1, 0, 50'hF);
    for (int v = 0; v < 8; v++) begin
      logic maj;
      drive({9'h1A5, 3'(v)});
      maj = (v == 3 || v == 5 || v == 6 || v == 7);
      #0.5 chk("R5 R2 R3 majority output", {5'd0, out_w[0]}, {5'd0, maj});
    end

    // R5: empty term 10 drives output 1
    wr(1'b0, 10, 50'h0);
    wr(1'b1, 1, 50'h1 << 10);
    drive(12'h000); #0.5 chk("R5 empty term is one", {5'd0, out_w[1]}, 6'd1);
    drive(12'hFFF); #0.5 chk("R5 empty term is one", {5'd0, out_w[1]}, 6'd1);

    // R6: term 11 holds both forms of input 0
    wr(1'b0, 11, 50'h3);
    wr(1'b1, 2, 50'h1 << 11);
    drive(12'h000); #0.5 chk("R6 conflict term zero", {5'd0, out_w[2]}, 6'd0);
    drive(12'h001); #0.5 chk("R6 conflict term zero", {5'd0, out_w[2]}, 6'd0);

    // R7: empty column 3 stays zero even with term 10 high
    wr(1'b1, 3, 50'h0);
    drive(12'h0F0); #0.5 chk("R7 empty column zero", {5'd0, out_w[3]}, 6'd0);

    // inverted literal: term 20 = !in5 & in6 on output 4
    wr(1'b0, 20, 50'h1800);
    wr(1'b1, 4, 50'h1 << 20);
    drive(12'h040); #0.5 chk("R2 inverted literal true", {5'd0, out_w[4]}, 6'd1);
    drive(12'h060); #0.5 chk("R2 inverted literal false", {5'd0, out_w[4]}, 6'd0);

    // R8: out-of-range writes
    drive(12'h003);
    wr(1'b0, 50, 50'h0);
    wr(1'b0, 63, 50'h0);
    wr(1'b1, 6, 50'h0);
    wr(1'b1, 7, '1);
    #0.5 chk("R8 oob writes ignored", out_w, 6'b000011);
    drive(12'h004); #0.5 chk("R8 oob writes ignored", out_w, 6'b000010);

    // R10: rewrite term 1 only, majority path of terms 0,2 intact
    wr(1'b0, 1, 50'h0);
    drive(12'h003); #0.5 chk("R10 other rows intact", {5'd0, out_w[0]}, 6'd1);
    drive(12'h006); #0.5 chk("R10 other rows intact", {5'd0, out_w[0]}, 6'd1);

    // R9: input change with no clock edge
    @(posedge clk); #1.2; in_s = 12'h040;
    #0.3 chk("R9 combinational path", out_w, model(12'h040));
    in_s = 12'h060;
    #0.3 chk("R9 combinational path", out_w, model(12'h060));

    // mixed traffic compared by the per-clock model
    for (int n = 0; n < 300; n++) begin
      logic [49:0] d = {$urandom, $urandom};
      if (n % 7 == 0) wr(n[3], $urandom_range(0, 55), d);
      else drive(12'($urandom));
    end

    repeat (2) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule